// File: doc/BRIEF.md
# Dual-Path Host Register Port

This block connects an 8-bit asynchronous microcontroller bus to a chip's internal register file. The host sees two locations, chosen by one address pin. Location 0 is an index register: writing it selects a target register address, and its top bit picks the write path. Location 1 is the data window: writing it sends one byte to the path chosen by the index, and reading it returns the selected register's contents straight from the register file.

Immediate-path bytes are queued in a FIFO and handed to the register file's write port. The port pops one entry per clock whenever the register file accepts it. Delayed-path bytes skip that FIFO and leave as one-cycle pushes towards a separate timed-write sequencer. Reading location 0 returns a status byte that reports FIFO overflow and FIFO empty.

The strobes pass through two-stage synchronisers into the core clock. A small state machine follows each access and acts when the strobe is released. Its states are HS_IDLE, HS_WR_HOLD, HS_WR_DONE, HS_RD_HOLD and HS_RD_DONE, with these transitions:
- HS_IDLE to HS_WR_HOLD when select and write are both seen low. Write wins over read.
- HS_IDLE to HS_RD_HOLD when select and read are both seen low.
- A hold state moves to its done state when select or the strobe is seen high.
- Each done state lasts one cycle and returns to HS_IDLE.

Top module: `host_regport`

## Requirements
- R1: After reset the following hold: hp_data_oe, rf_wr_valid and seq_push are 0; rf_rd_addr is 0; the status byte reads 0x02.
- R2: A completed write with hp_addr=0 loads the index register. rf_rd_addr then shows index bits 6:0. Index bit 7 picks the path: 0 is immediate, 1 is delayed.
- R3: A write with hp_addr=1 while index bit 7 is 0 appears on rf_wr_addr/rf_wr_data with the address equal to index bits 6:0. The index does not advance, so repeated data writes all go to the same register.
- R4: A write with hp_addr=1 while index bit 7 is 1 produces exactly one seq_push cycle carrying the byte. It produces no register-file write.
- R5: While hp_addr=1, hp_data_out equals rf_rd_data for address index bits 6:0, with no clock delay.
- R6: hp_data_oe is 1 only while hp_cs_n and hp_rd_n are both low.
- R7: Queued immediate writes leave in the order written, one per clock while rf_wr_accept is 1. While rf_wr_accept is 0, the head entry stays presented and nothing is lost.
- R8: An immediate write that arrives while the FIFO holds FIFO_DEPTH entries is dropped and sets the sticky overflow bit.
- R9: Reading with hp_addr=0 returns a status byte: bit 0 is overflow, bit 1 is FIFO empty, all other bits are 0. Overflow is cleared when such a status read completes.
- R10: Strobe activity while hp_cs_n is high has no effect.
- R11: A write takes effect only after hp_wr_n returns high. Nothing is issued while the strobe is still held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_cs_n | input | 1 | Host chip select, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_addr | input | 1 | 0 = index/status, 1 = data window |
| hp_data_in | input | 8 | Host bus, inbound |
| hp_data_out | output | 8 | Host bus, outbound |
| hp_data_oe | output | 1 | Host bus drive enable |
| rf_rd_addr | output | 7 | Register file read address |
| rf_rd_data | input | 8 | Register file read data |
| rf_wr_addr | output | 7 | Register file write address |
| rf_wr_data | output | 8 | Register file write data |
| rf_wr_valid | output | 1 | Write entry presented |
| rf_wr_accept | input | 1 | Register file takes the entry this clock |
| seq_data | output | 8 | Byte to the sequencer FIFO |
| seq_push | output | 1 | One-cycle push to the sequencer FIFO |

## Verification
Overflow is the hardest condition to reach from the ports. Each host access takes several core clocks, so an unstalled queue drains far faster than the host can fill it. The stimulus therefore holds rf_wr_accept low through 65 immediate writes to fill the FIFO and force one drop. It then reads the status byte and releases the stall. Finally it checks that exactly the first 64 bytes come out, in order, and that the status read cleared the flag.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int HOST_W   = 8;
    localparam int REG_AW   = HOST_W - 1;
    localparam int PATH_BIT = HOST_W - 1;

    localparam int ST_OVF_BIT   = 0;
    localparam int ST_EMPTY_BIT = 1;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_WR_HOLD,
        HS_WR_DONE,
        HS_RD_HOLD,
        HS_RD_DONE
    } hs_state_e;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [HOST_W-1:0] data;
    } wr_entry_t;

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hrp_strobe_fsm.sv
module hrp_strobe_fsm
    import hrp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_n,
    input  logic wr_s_n,
    input  logic rd_s_n,
    output logic capture,
    output logic wr_commit,
    output logic rd_commit
);

    hs_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: begin
                if (!cs_s_n && !wr_s_n)      state_d = HS_WR_HOLD;
                else if (!cs_s_n && !rd_s_n) state_d = HS_RD_HOLD;
            end
            HS_WR_HOLD: if (cs_s_n || wr_s_n) state_d = HS_WR_DONE;
            HS_WR_DONE: state_d = HS_IDLE;
            HS_RD_HOLD: if (cs_s_n || rd_s_n) state_d = HS_RD_DONE;
            HS_RD_DONE: state_d = HS_IDLE;
            default:    state_d = HS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture   = 1'b0;
        wr_commit = 1'b0;
        rd_commit = 1'b0;
        unique case (state_q)
            HS_IDLE:    capture = !cs_s_n && (!wr_s_n || !rd_s_n);
            HS_WR_HOLD: capture = !cs_s_n && !wr_s_n;
            HS_RD_HOLD: capture = !cs_s_n && !rd_s_n;
            HS_WR_DONE: wr_commit = 1'b1;
            HS_RD_DONE: rd_commit = 1'b1;
            default:    capture = 1'b0;
        endcase
    end

endmodule

// File: rtl/hrp_fifo.sv
module hrp_fifo
    import hrp_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t push_entry,
    input  logic      pop,
    output wr_entry_t head,
    output logic      empty,
    output logic      full
);

    wr_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/host_regport.sv
module host_regport
    import hrp_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_cs_n,
    input  logic              hp_wr_n,
    input  logic              hp_rd_n,
    input  logic              hp_addr,
    input  logic [HOST_W-1:0] hp_data_in,
    output logic [HOST_W-1:0] hp_data_out,
    output logic              hp_data_oe,
    output logic [REG_AW-1:0] rf_rd_addr,
    input  logic [HOST_W-1:0] rf_rd_data,
    output logic [REG_AW-1:0] rf_wr_addr,
    output logic [HOST_W-1:0] rf_wr_data,
    output logic              rf_wr_valid,
    input  logic              rf_wr_accept,
    output logic [HOST_W-1:0] seq_data,
    output logic              seq_push
);

    logic cs_s_n, wr_s_n, rd_s_n;

    hrp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hp_cs_n, hp_wr_n, hp_rd_n}),
        .q     ({cs_s_n, wr_s_n, rd_s_n})
    );

    logic capture, wr_commit, rd_commit;

    hrp_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s_n    (cs_s_n),
        .wr_s_n    (wr_s_n),
        .rd_s_n    (rd_s_n),
        .capture   (capture),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit)
    );

    logic              cap_addr_q;
    logic [HOST_W-1:0] cap_data_q;
    logic [HOST_W-1:0] index_q;
    logic              ovf_q;
    logic              seq_push_q;
    logic [HOST_W-1:0] seq_data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr_q <= 1'b0;
            cap_data_q <= '0;
        end else if (capture) begin
            cap_addr_q <= hp_addr;
            cap_data_q <= hp_data_in;
        end
    end

    logic imm_req, dly_req, fifo_push, fifo_full, fifo_empty, fifo_pop;
    wr_entry_t fifo_in, fifo_head;

    assign imm_req   = wr_commit && cap_addr_q && !index_q[PATH_BIT];
    assign dly_req   = wr_commit && cap_addr_q &&  index_q[PATH_BIT];
    assign fifo_push = imm_req && !fifo_full;
    assign fifo_in   = '{addr: index_q[REG_AW-1:0], data: cap_data_q};
    assign fifo_pop  = rf_wr_valid && rf_wr_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q    <= '0;
            ovf_q      <= 1'b0;
            seq_push_q <= 1'b0;
            seq_data_q <= '0;
        end else begin
            if (wr_commit && !cap_addr_q) index_q <= cap_data_q;
            if (imm_req && fifo_full)          ovf_q <= 1'b1;
            else if (rd_commit && !cap_addr_q) ovf_q <= 1'b0;
            seq_push_q <= dly_req;
            if (dly_req) seq_data_q <= cap_data_q;
        end
    end

    hrp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fifo_push),
        .push_entry (fifo_in),
        .pop        (fifo_pop),
        .head       (fifo_head),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    assign rf_wr_valid = !fifo_empty;
    assign rf_wr_addr  = fifo_head.addr;
    assign rf_wr_data  = fifo_head.data;
    assign seq_push    = seq_push_q;
    assign seq_data    = seq_data_q;
    assign rf_rd_addr  = index_q[REG_AW-1:0];

    logic [HOST_W-1:0] status;
    always_comb begin
        status               = '0;
        status[ST_OVF_BIT]   = ovf_q;
        status[ST_EMPTY_BIT] = fifo_empty;
    end

    assign hp_data_out = hp_addr ? rf_rd_data : status;
    assign hp_data_oe  = !hp_cs_n && !hp_rd_n;

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_commit,
    input logic       rd_commit,
    input logic       cap_addr,
    input logic [7:0] cap_data,
    input logic       index_path,
    input logic       imm_req,
    input logic       fifo_full,
    input logic       fifo_push,
    input logic       ovf,
    input logic       rf_wr_valid,
    input logic       rf_wr_accept,
    input logic [7:0] rf_wr_data,
    input logic [6:0] rf_rd_addr,
    input logic       seq_push,
    input logic [7:0] seq_data
);

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !cap_addr) |=> (rf_rd_addr == $past(cap_data[6:0])));

    // R4
    dly_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && cap_addr && index_path) |=> (seq_push && seq_data == $past(cap_data)));

    // R4
    dly_no_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && index_path) |-> !fifo_push);

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_valid && !rf_wr_accept) |=> (rf_wr_valid && $stable(rf_wr_data)));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_req && fifo_full) |=> ovf);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !rd_commit) |=> ovf);

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_commit && !cap_addr) |=> !ovf);

endmodule

bind host_regport hrp_checker u_hrp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_commit    (wr_commit),
    .rd_commit    (rd_commit),
    .cap_addr     (cap_addr_q),
    .cap_data     (cap_data_q),
    .index_path   (index_q[7]),
    .imm_req      (imm_req),
    .fifo_full    (fifo_full),
    .fifo_push    (fifo_push),
    .ovf          (ovf_q),
    .rf_wr_valid  (rf_wr_valid),
    .rf_wr_accept (rf_wr_accept),
    .rf_wr_data   (rf_wr_data),
    .rf_rd_addr   (rf_rd_addr),
    .seq_push     (seq_push),
    .seq_data     (seq_data)
);

// File: tb/host_regport_bench.sv
`timescale 1ns/1ps
module host_regport_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_cs_n = 1'b1, hp_wr_n = 1'b1, hp_rd_n = 1'b1, hp_addr = 1'b0;
    logic [7:0] hp_data_in = '0;
    logic [7:0] hp_data_out;
    logic       hp_data_oe;
    logic [6:0] rf_rd_addr, rf_wr_addr;
    logic [7:0] rf_rd_data, rf_wr_data, seq_data;
    logic       rf_wr_valid, seq_push;
    logic       rf_wr_accept = 1'b1;

    always #4 clk = ~clk;

    assign rf_rd_data = {1'b0, rf_rd_addr} ^ 8'h5A;

    host_regport u_host_regport (
        .clk(clk), .rst_n(rst_n), .hp_cs_n(hp_cs_n), .hp_wr_n(hp_wr_n),
        .hp_rd_n(hp_rd_n), .hp_addr(hp_addr), .hp_data_in(hp_data_in),
        .hp_data_out(hp_data_out), .hp_data_oe(hp_data_oe),
        .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
        .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
        .rf_wr_valid(rf_wr_valid), .rf_wr_accept(rf_wr_accept),
        .seq_data(seq_data), .seq_push(seq_push)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // output logs sampled mid-cycle
    logic [6:0] rf_la [256];
    logic [7:0] rf_ld [256];
    logic [7:0] sq_ld [256];
    int rf_n = 0, sq_n = 0;

    always begin
        @(negedge clk);
        #2;
        if (rf_wr_valid && rf_wr_accept && rf_n < 256) begin
            rf_la[rf_n] = rf_wr_addr;
            rf_ld[rf_n] = rf_wr_data;
            rf_n++;
        end
        if (seq_push && sq_n < 256) begin
            sq_ld[sq_n] = seq_data;
            sq_n++;
        end
    end

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        hp_addr = a; hp_data_in = d; hp_cs_n = 1'b0;
        @(negedge clk);
        hp_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        hp_wr_n = 1'b1;
        @(negedge clk);
        hp_cs_n = 1'b1;
        repeat (7) @(negedge clk);
    endtask

    task automatic host_read(input logic a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        hp_addr = a; hp_cs_n = 1'b0; hp_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        d = hp_data_out; oe = hp_data_oe;
        @(negedge clk);
        hp_rd_n = 1'b1; hp_cs_n = 1'b1;
        repeat (7) @(negedge clk);
    endtask

    // {index byte, data byte}
    localparam logic [15:0] VEC [8] = '{
        16'h03_11, 16'h83_22, 16'h7F_FF, 16'h00_00,
        16'h81_5A, 16'h2A_A5, 16'hC0_01, 16'h15_3C
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        int         b, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        check(hp_data_oe == 0, "R1 oe", hp_data_oe, 0);
        check(rf_wr_valid == 0, "R1 rf_wr_valid", rf_wr_valid, 0);
        check(seq_push == 0, "R1 seq_push", seq_push, 0);
        check(rf_rd_addr == 0, "R1 rf_rd_addr", rf_rd_addr, 0);
        host_read(1'b0, rd, oe);
        check(rd == 8'h02, "R1 R9 status", rd, 8'h02);
        check(oe == 1, "R6 oe during read", oe, 1);

        // vector table: R2 R3 R4
        foreach (VEC[i]) begin
            logic [7:0] ix, dt;
            ix = VEC[i][15:8]; dt = VEC[i][7:0];
            b = rf_n; s = sq_n;
            host_write(1'b0, ix);
            check(rf_rd_addr == ix[6:0], "R2 index", rf_rd_addr, ix[6:0]);
            host_write(1'b1, dt);
            if (ix[7]) begin
                check(sq_n == s + 1 && sq_ld[s] == dt, "R4 seq byte", sq_ld[s], dt);
                check(rf_n == b, "R4 no rf write", rf_n, b);
            end else begin
                check(rf_n == b + 1 && rf_ld[b] == dt && rf_la[b] == ix[6:0],
                      "R3 rf write", {rf_la[b], rf_ld[b]}, {ix[6:0], dt});
                check(sq_n == s, "R3 no seq push", sq_n, s);
            end
            host_read(1'b1, rd, oe);
            check(rd == ({1'b0, ix[6:0]} ^ 8'h5A), "R5 read", rd, {1'b0, ix[6:0]} ^ 8'h5A);
        end

        // R3: no auto-advance
        host_write(1'b0, 8'h44);
        b = rf_n;
        host_write(1'b1, 8'h01);
        host_write(1'b1, 8'h02);
        check(rf_n == b + 2 && rf_la[b] == 7'h44 && rf_la[b+1] == 7'h44,
              "R3 same address", rf_la[b+1], 7'h44);

        // R6: read strobe without select
        @(negedge clk); hp_rd_n = 1'b0; #1;
        check(hp_data_oe == 0, "R6 oe without cs", hp_data_oe, 0);
        @(negedge clk); hp_rd_n = 1'b1;

        // R10: writes without select ignored
        b = rf_n; s = sq_n;
        @(negedge clk); hp_addr = 1'b0; hp_data_in = 8'h7F; hp_wr_n = 1'b0;
        repeat (5) @(negedge clk); hp_wr_n = 1'b1;
        @(negedge clk); hp_addr = 1'b1; hp_wr_n = 1'b0;
        repeat (5) @(negedge clk); hp_wr_n = 1'b1;
        repeat (8) @(negedge clk); #1;
        check(rf_rd_addr == 7'h44, "R10 index kept", rf_rd_addr, 7'h44);
        check(rf_n == b && sq_n == s, "R10 nothing issued", rf_n + sq_n, b + s);

        // R11: commit only on release
        b = rf_n;
        @(negedge clk); hp_addr = 1'b1; hp_data_in = 8'h77; hp_cs_n = 1'b0;
        @(negedge clk); hp_wr_n = 1'b0;
        repeat (12) @(negedge clk); #1;
        check(rf_n == b, "R11 held strobe", rf_n, b);
        hp_wr_n = 1'b1;
        @(negedge clk); hp_cs_n = 1'b1;
        repeat (7) @(negedge clk); #1;
        check(rf_n == b + 1 && rf_ld[b] == 8'h77, "R11 after release", rf_ld[b], 8'h77);

        // R7: stall, order, one per clock
        rf_wr_accept = 1'b0;
        host_write(1'b0, 8'h22);
        b = rf_n;
        host_write(1'b1, 8'hA1);
        host_write(1'b1, 8'hA2);
        host_write(1'b1, 8'hA3);
        #1;
        check(rf_wr_valid == 1 && rf_wr_data == 8'hA1, "R7 head held", rf_wr_data, 8'hA1);
        check(rf_n == b, "R7 none while stalled", rf_n, b);
        @(negedge clk); rf_wr_accept = 1'b1;
        @(negedge clk); #1;
        check(rf_n == b + 1, "R7 one per clock", rf_n, b + 1);
        repeat (3) @(negedge clk); #1;
        check(rf_n == b + 3 && rf_ld[b] == 8'hA1 && rf_ld[b+1] == 8'hA2 && rf_ld[b+2] == 8'hA3,
              "R7 order", rf_ld[b+2], 8'hA3);

        // R8 R9: overflow
        rf_wr_accept = 1'b0;
        host_write(1'b0, 8'h05);
        b = rf_n;
        for (int k = 0; k < 65; k++) host_write(1'b1, 8'(k));
        host_read(1'b0, rd, oe);
        check(rd == 8'h01, "R8 R9 overflow status", rd, 8'h01);
        @(negedge clk); rf_wr_accept = 1'b1;
        repeat (70) @(negedge clk); #1;
        check(rf_n == b + 64, "R8 drop count", rf_n - b, 64);
        check(rf_ld[b] == 8'h00 && rf_ld[b+63] == 8'd63, "R8 kept entries", rf_ld[b+63], 63);
        host_read(1'b0, rd, oe);
        check(rd == 8'h02, "R9 cleared by read", rd, 8'h02);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule